// File: doc/BRIEF.md
# SPI Master Chip-Select Handshake Controller

This block sits between a request source and an SPI master shift engine and decides when each word may be clocked. When a word is requested it pulls chip select low at once. It then holds off the shift engine in one of two ways. In five-pin mode it waits for the slave to pull its active-low enable line. In four-pin mode it counts a programmed setup time. When that condition is met it issues a one-cycle start pulse and waits for the engine's done pulse.

After a word, chip select is either kept low for the next word of the same frame (hold flag set) or released after a programmed hold delay. Once released it stays high for a programmed idle time of at least one cycle before it can fall again. In five-pin mode, a slave that never asserts enable within the programmed timeout causes the word to be aborted and a sticky error flag to be raised. The flag clears when the next word is launched.

Top module: `spi_cs_handshake`

## Requirements
- R1: During and right after reset, cs_no is 1, shift_start_o is 0 and timeout_o is 0.
- R2: A request (req_i high) sampled while idle drives cs_no low on the next clock edge; with req_i low an idle controller keeps cs_no high and issues no start.
- R3: In four-pin mode (five_pin_i = 0), shift_start_o rises exactly setup_cyc_i + 1 cycles after cs_no falls.
- R4: In five-pin mode (five_pin_i = 1), setup_cyc_i is ignored and shift_start_o rises on the edge after the first cycle in which slave_en_ni is sampled low.
- R5: In five-pin mode, if slave_en_ni stays high for timeout_cyc_i + 1 cycles after cs_no falls, no start is issued, timeout_o goes to 1, and the release then follows R8. If enable is sampled low in the same cycle the timeout count expires, the start wins and timeout_o stays 0.
- R6: timeout_o stays 1 until the next word is launched and returns to 0 on the same edge where that word's pre-clock phase begins.
- R7: shift_start_o is a single-cycle pulse, only while cs_no is low, and cs_no stays low while the controller waits for shift_done_i.
- R8: When shift_done_i is sampled with hold_i = 0, cs_no stays low for hold_cyc_i + 1 more cycles and then goes high.
- R9: When shift_done_i is sampled with hold_i = 1, cs_no stays low indefinitely. A request then starts the next word's pre-clock phase on the next edge without cs_no rising. Dropping hold_i with no request pending starts the hold delay of R8.
- R10: After cs_no rises it stays high for at least idle_cyc_i + 1 cycles. With a request pending it falls again after exactly idle_cyc_i + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Word pending; sampled only when a word may launch |
| hold_i | input | 1 | Keep chip select low after the current word |
| five_pin_i | input | 1 | 1: wait for slave enable, 0: count setup delay |
| setup_cyc_i | input | CNT_W | Four-pin setup delay in cycles |
| hold_cyc_i | input | CNT_W | Delay from word end to chip-select release |
| idle_cyc_i | input | CNT_W | Extra chip-select high time beyond one cycle |
| timeout_cyc_i | input | CNT_W | Five-pin enable wait limit |
| slave_en_ni | input | 1 | Slave enable, active low |
| shift_start_o | output | 1 | One-cycle start pulse to shift engine |
| shift_done_i | input | 1 | One-cycle done pulse from shift engine |
| cs_no | output | 1 | Chip select, active low |
| timeout_o | output | 1 | Sticky enable-timeout error flag |

## Verification
The enable wait and its timeout can both resolve in one cycle: the slave may pull enable low in the very cycle the timeout counter reaches zero. The bench sweeps the enable arrival across every cycle of a short timeout window, including that last cycle. It expects a start one edge later with the error flag still clear. A second coincidence arises when the idle counter expires while a request is pending. The four-pin sweep chains words back to back so that every idle setting is measured with the relaunch happening on that expiry edge.

// File: rtl/spi_csh_pkg.sv
package spi_csh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_EN,
    ST_SHIFT,
    ST_LINK,
    ST_HOLD,
    ST_GAP
  } csh_state_e;
endpackage

// File: rtl/csh_counter.sv
module csh_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/csh_fsm.sv
module csh_fsm
  import spi_csh_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             hold_i,
  input  logic             five_pin_i,
  input  logic [CNT_W-1:0] setup_cyc_i,
  input  logic [CNT_W-1:0] hold_cyc_i,
  input  logic [CNT_W-1:0] idle_cyc_i,
  input  logic [CNT_W-1:0] timeout_cyc_i,
  input  logic             slave_en_ni,
  input  logic             shift_done_i,
  input  logic             cnt_zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             dec_o,
  output logic             cs_no,
  output logic             shift_start_o,
  output logic             timeout_o
);
  csh_state_e state_q, state_d;
  logic start_d, tmo_set, tmo_clr;
  logic cs_n_q, start_q, tmo_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    dec_o      = 1'b0;
    start_d    = 1'b0;
    tmo_set    = 1'b0;
    tmo_clr    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d    = five_pin_i ? ST_WAIT_EN : ST_SETUP;
        load_o     = 1'b1;
        load_val_o = five_pin_i ? timeout_cyc_i : setup_cyc_i;
        tmo_clr    = 1'b1;
      end
      ST_SETUP: begin
        if (cnt_zero_i) begin
          state_d = ST_SHIFT;
          start_d = 1'b1;
        end else dec_o = 1'b1;
      end
      ST_WAIT_EN: begin
        // enable wins over an expiring timeout
        if (!slave_en_ni) begin
          state_d = ST_SHIFT;
          start_d = 1'b1;
        end else if (cnt_zero_i) begin
          state_d    = ST_HOLD;
          load_o     = 1'b1;
          load_val_o = hold_cyc_i;
          tmo_set    = 1'b1;
        end else dec_o = 1'b1;
      end
      ST_SHIFT: if (shift_done_i) begin
        if (hold_i) state_d = ST_LINK;
        else begin
          state_d    = ST_HOLD;
          load_o     = 1'b1;
          load_val_o = hold_cyc_i;
        end
      end
      ST_LINK: begin
        if (req_i) begin
          state_d    = five_pin_i ? ST_WAIT_EN : ST_SETUP;
          load_o     = 1'b1;
          load_val_o = five_pin_i ? timeout_cyc_i : setup_cyc_i;
          tmo_clr    = 1'b1;
        end else if (!hold_i) begin
          state_d    = ST_HOLD;
          load_o     = 1'b1;
          load_val_o = hold_cyc_i;
        end
      end
      ST_HOLD: begin
        if (cnt_zero_i) begin
          state_d    = ST_GAP;
          load_o     = 1'b1;
          load_val_o = idle_cyc_i;
        end else dec_o = 1'b1;
      end
      ST_GAP: begin
        if (!cnt_zero_i) dec_o = 1'b1;
        else if (req_i) begin
          state_d    = five_pin_i ? ST_WAIT_EN : ST_SETUP;
          load_o     = 1'b1;
          load_val_o = five_pin_i ? timeout_cyc_i : setup_cyc_i;
          tmo_clr    = 1'b1;
        end else state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      start_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= (state_d == ST_IDLE) || (state_d == ST_GAP);
      start_q <= start_d;
      if (tmo_set)      tmo_q <= 1'b1;
      else if (tmo_clr) tmo_q <= 1'b0;
    end
  end

  assign cs_no         = cs_n_q;
  assign shift_start_o = start_q;
  assign timeout_o     = tmo_q;
endmodule

// File: rtl/spi_cs_handshake.sv
module spi_cs_handshake #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             hold_i,
  input  logic             five_pin_i,
  input  logic [CNT_W-1:0] setup_cyc_i,
  input  logic [CNT_W-1:0] hold_cyc_i,
  input  logic [CNT_W-1:0] idle_cyc_i,
  input  logic [CNT_W-1:0] timeout_cyc_i,
  input  logic             slave_en_ni,
  output logic             shift_start_o,
  input  logic             shift_done_i,
  output logic             cs_no,
  output logic             timeout_o
);
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_load_val;

  csh_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .hold_i        (hold_i),
    .five_pin_i    (five_pin_i),
    .setup_cyc_i   (setup_cyc_i),
    .hold_cyc_i    (hold_cyc_i),
    .idle_cyc_i    (idle_cyc_i),
    .timeout_cyc_i (timeout_cyc_i),
    .slave_en_ni   (slave_en_ni),
    .shift_done_i  (shift_done_i),
    .cnt_zero_i    (cnt_zero),
    .load_o        (cnt_load),
    .load_val_o    (cnt_load_val),
    .dec_o         (cnt_dec),
    .cs_no         (cs_no),
    .shift_start_o (shift_start_o),
    .timeout_o     (timeout_o)
  );

  csh_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );
endmodule

// File: rtl/csh_checker.sv
module csh_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             five_pin_i,
  input logic [CNT_W-1:0] idle_cyc_i,
  input logic             slave_en_ni,
  input logic             shift_start_o,
  input logic             cs_no,
  input logic             timeout_o
);
  // R7
  start_cs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_start_o |-> !cs_no);

  // R7
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_start_o |=> !shift_start_o);

  // R4
  en_before_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_start_o && five_pin_i) |-> $past(!slave_en_ni));

  // R5
  timeout_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(slave_en_ni) && five_pin_i));

  // R6
  timeout_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> $fell(cs_no));

  // R10
  idle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no) && $past(idle_cyc_i) != '0) |=> cs_no);
endmodule

bind spi_cs_handshake csh_checker #(.CNT_W(CNT_W)) u_csh_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .five_pin_i    (five_pin_i),
  .idle_cyc_i    (idle_cyc_i),
  .slave_en_ni   (slave_en_ni),
  .shift_start_o (shift_start_o),
  .cs_no         (cs_no),
  .timeout_o     (timeout_o)
);

// File: tb/tb_spi_cs_handshake.sv
module tb_spi_cs_handshake;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, hold_i = 1'b0, five_pin_i = 1'b0;
  logic [CNT_W-1:0] setup_cyc_i = '0, hold_cyc_i = '0, idle_cyc_i = '0, timeout_cyc_i = '0;
  logic slave_en_ni = 1'b1, shift_done_i = 1'b0;
  logic shift_start_o, cs_no, timeout_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  spi_cs_handshake #(.CNT_W(CNT_W)) dut (
    .clk_i, .rst_ni, .req_i, .hold_i, .five_pin_i,
    .setup_cyc_i, .hold_cyc_i, .idle_cyc_i, .timeout_cyc_i,
    .slave_en_ni, .shift_start_o, .shift_done_i, .cs_no, .timeout_o
  );

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // from the word's start pulse: done, then count release cycles
  task automatic finish_word(input string tag, input int hold_exp);
    int n;
    tick();
    check("R7 start single pulse", int'(shift_start_o), 0);
    check("R7 cs low while shifting", int'(cs_no), 0);
    shift_done_i = 1'b1;
    tick();
    shift_done_i = 1'b0;
    n = 0;
    while (cs_no == 1'b0 && n < 40) begin n++; tick(); end
    check(tag, n, hold_exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic saw, stayed;
    tick();
    check("R1 cs in reset", int'(cs_no), 1);
    rst_ni = 1'b1;
    tick();
    check("R1 cs after reset", int'(cs_no), 1);
    check("R1 start after reset", int'(shift_start_o), 0);
    check("R1 timeout after reset", int'(timeout_o), 0);
    repeat (3) tick();
    check("R2 idle without request", int'(cs_no), 1);

    // four-pin sweep, words chained through the idle gap
    req_i = 1'b1;
    tick();
    check("R2 cs falls on request", int'(cs_no), 0);
    for (int k = 0; k < 64; k++) begin
      hold_cyc_i = CNT_W'(k / 4 % 4);
      idle_cyc_i = CNT_W'(k / 16);
      n = 0;
      while (!shift_start_o && n < 40) begin tick(); n++; end
      check("R3 setup delay", n, k % 4 + 1);
      req_i = 1'b0;
      finish_word("R8 hold delay", k / 4 % 4 + 1);
      if (k < 63) begin
        setup_cyc_i = CNT_W'((k + 1) % 4);
        req_i = 1'b1;
        n = 0;
        while (cs_no == 1'b1 && n < 40) begin n++; tick(); end
        check("R10 idle gap", n, k / 16 + 1);
      end
    end
    saw = 1'b0;
    repeat (8) begin tick(); if (!cs_no || shift_start_o) saw = 1'b1; end
    check("R2 stays idle", int'(saw), 0);

    // five-pin: enable arrival swept over the whole timeout window
    five_pin_i = 1'b1;
    setup_cyc_i = 8'd7;
    timeout_cyc_i = 8'd3;
    hold_cyc_i = 8'd1;
    idle_cyc_i = 8'd0;
    for (int e = 0; e < 4; e++) begin
      slave_en_ni = 1'b1;
      req_i = 1'b1;
      tick();
      n = 0;
      saw = 1'b0;
      repeat (e) begin tick(); n++; if (shift_start_o) saw = 1'b1; end
      check("R4 no start before enable", int'(saw), 0);
      slave_en_ni = 1'b0;
      while (!shift_start_o && n < 40) begin tick(); n++; end
      check("R4 start after enable", n, e + 1);
      check("R5 enable beats expiry", int'(timeout_o), 0);
      req_i = 1'b0;
      slave_en_ni = 1'b1;
      finish_word("R8 hold delay five-pin", 2);
      repeat (3) tick();
    end

    // five-pin timeout, then next word clears the flag
    hold_cyc_i = 8'd0;
    for (int t = 2; t < 6; t += 3) begin
      five_pin_i = 1'b1;
      timeout_cyc_i = CNT_W'(t);
      req_i = 1'b1;
      tick();
      n = 0;
      saw = 1'b0;
      while (!timeout_o && n < 40) begin tick(); n++; if (shift_start_o) saw = 1'b1; end
      req_i = 1'b0;
      check("R5 timeout latency", n, t + 1);
      check("R5 no start on timeout", int'(saw), 0);
      n = 0;
      while (cs_no == 1'b0 && n < 40) begin n++; tick(); end
      check("R5 release after abort", n, 1);
      repeat (3) tick();
      check("R6 flag sticky", int'(timeout_o), 1);
      five_pin_i = 1'b0;
      setup_cyc_i = 8'd0;
      req_i = 1'b1;
      tick();
      check("R6 flag cleared at launch", int'(timeout_o), 0);
      tick();
      check("R3 start zero setup", int'(shift_start_o), 1);
      req_i = 1'b0;
      finish_word("R8 hold zero", 1);
      repeat (3) tick();
    end

    // hold across words
    five_pin_i = 1'b0;
    setup_cyc_i = 8'd1;
    hold_cyc_i = 8'd2;
    idle_cyc_i = 8'd1;
    hold_i = 1'b1;
    req_i = 1'b1;
    tick();
    while (!shift_start_o) tick();
    req_i = 1'b0;
    tick();
    shift_done_i = 1'b1;
    tick();
    shift_done_i = 1'b0;
    stayed = 1'b1;
    repeat (5) begin tick(); if (cs_no) stayed = 1'b0; end
    check("R9 cs held between words", int'(stayed), 1);
    req_i = 1'b1;
    n = 0;
    while (!shift_start_o && n < 40) begin tick(); n++; if (cs_no) stayed = 1'b0; end
    req_i = 1'b0;
    check("R9 linked word start", n, 3);
    tick();
    shift_done_i = 1'b1;
    tick();
    shift_done_i = 1'b0;
    repeat (2) begin tick(); if (cs_no) stayed = 1'b0; end
    check("R9 frame never released", int'(stayed), 1);
    hold_i = 1'b0;
    tick();
    n = 0;
    while (cs_no == 1'b0 && n < 40) begin n++; tick(); end
    check("R9 release after hold dropped", n, 3);
    repeat (4) tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule